// File: doc/BRIEF.md
# Multi-Mode Effective Address Generator

This block is a purely combinational address unit for a load/store pipeline. From a decoded mode code, the program counter, two register read values (a base and an index), a 32-bit immediate/displacement field, a scale code and an operand-size code, it forms the 32-bit effective address of a memory operand or a jump target. It can also produce a post-incremented copy of the base register, together with a write-back enable.

Decode, register file access and memory access sit outside the block. The pipeline drives the decoded fields in, and then uses `effAddr` for the access. It writes `newBase` back to the base register whenever `baseWrEn` is high.

Top module: `eff_addr_gen`

## Requirements
- R1: With `modeSel` = 0 (base+offset), `effAddr` = `baseVal` + sign-extended `immField[15:0]`; `immField[31:16]` is ignored.
- R2: With `modeSel` = 1 (PC-relative), `effAddr` = `pcVal` + sign-extended `immField[15:0]`.
- R3: With `modeSel` = 2 (jump target), `effAddr` = {`pcVal[31:28]`, `immField[25:0]`, 2'b00}.
- R4: With `modeSel` = 3 (indexed), `effAddr` = `baseVal` + `indexVal`.
- R5: With `modeSel` = 4 (scaled index), `effAddr` = `baseVal` + (`indexVal` << `scaleCode`) + displacement. `scaleCode` 0..3 gives a factor of 1, 2, 4 or 8, and index bits shifted past bit 31 are dropped.
- R6: In `modeSel` = 4, `dispSel` picks the displacement: 0 adds none, 1 adds sign-extended `immField[7:0]`, 2 adds all of `immField[31:0]`, and 3 adds none.
- R7: With `modeSel` = 5 (update), `effAddr` is formed as in R1 from the un-incremented base. `baseWrEn` = 1, and `newBase` = `baseVal` + step, where `sizeCode` 0 gives a step of 1, 1 gives 2, and 2 or 3 give 4.
- R8: With `modeSel` = 6 (register indirect), `effAddr` = `baseVal`, whatever the immediate and index are.
- R9: All sums wrap modulo 2^32.
- R10: For every `modeSel` other than 5, `baseWrEn` = 0 and `newBase` = `baseVal`. The unused code 7 gives `effAddr` = 0.
- R11: `dispSel`, `scaleCode` and `sizeCode` have no effect on `effAddr` in modes that do not use them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| modeSel | input | 3 | Decoded addressing mode code (0..7) |
| dispSel | input | 2 | Displacement choice for scaled-index mode |
| scaleCode | input | 2 | Index shift amount (factor 1/2/4/8) |
| sizeCode | input | 2 | Operand size for update-mode increment |
| pcVal | input | 32 | Program counter of the instruction |
| baseVal | input | 32 | Base register read value |
| indexVal | input | 32 | Index register read value |
| immField | input | 32 | Immediate / displacement / jump field |
| effAddr | output | 32 | Effective address |
| newBase | output | 32 | Base value to write back |
| baseWrEn | output | 1 | Base write-back enable |

## Verification
The hardest situations to reach are those where two parts of a sum carry into the same high bits. A scaled index that drops its top bits and a base increment that wraps past 2^32 are the clearest cases, because a wrong adder width or a wrong shift order can still give correct low bits. The vectors set the high bits of the base and the index on purpose: an index of 0x2000_0001 scaled by 8 and a base of 0xFFFF_FFFE stepped by a word both give results that are correct only if the wrap happens at bit 32. Junk is also placed in ignored field bits, so an error in a field slice shows up in the address.

// File: rtl/eag_pkg.sv
package eag_pkg;

  typedef enum logic [2:0] {
    MODE_BASE_OFS = 3'd0,
    MODE_PC_REL   = 3'd1,
    MODE_JUMP     = 3'd2,
    MODE_INDEXED  = 3'd3,
    MODE_SCALED   = 3'd4,
    MODE_UPDATE   = 3'd5,
    MODE_REG_IND  = 3'd6,
    MODE_NONE     = 3'd7
  } mode_e;

  typedef enum logic [0:0] {SRC_A_BASE, SRC_A_PC} srcA_e;
  typedef enum logic [1:0] {SRC_B_ZERO, SRC_B_IMM, SRC_B_INDEX} srcB_e;
  typedef enum logic [1:0] {SRC_C_ZERO, SRC_C_NARROW, SRC_C_WIDE} srcC_e;

  typedef struct packed {
    srcA_e      aSel;
    srcB_e      bSel;
    srcC_e      cSel;
    logic [1:0] shiftAmt;
    logic       jumpPath;
    logic       zeroOut;
    logic       wbEn;
    logic [2:0] incStep;
  } eagStrobes_t;

endpackage

// File: rtl/eag_ctrl.sv
module eag_ctrl
  import eag_pkg::*;
(
  input  logic [2:0]  modeSel,
  input  logic [1:0]  dispSel,
  input  logic [1:0]  scaleCode,
  input  logic [1:0]  sizeCode,
  output eagStrobes_t strobes
);

  mode_e modeE;
  assign modeE = mode_e'(modeSel);

  always_comb begin
    strobes          = '0;
    strobes.aSel     = SRC_A_BASE;
    strobes.bSel     = SRC_B_ZERO;
    strobes.cSel     = SRC_C_ZERO;
    unique case (modeE)
      MODE_BASE_OFS: strobes.bSel = SRC_B_IMM;
      MODE_PC_REL: begin
        strobes.aSel = SRC_A_PC;
        strobes.bSel = SRC_B_IMM;
      end
      MODE_JUMP:     strobes.jumpPath = 1'b1;
      MODE_INDEXED:  strobes.bSel = SRC_B_INDEX;
      MODE_SCALED: begin
        strobes.bSel     = SRC_B_INDEX;
        strobes.shiftAmt = scaleCode;
        case (dispSel)
          2'd1:    strobes.cSel = SRC_C_NARROW;
          2'd2:    strobes.cSel = SRC_C_WIDE;
          default: strobes.cSel = SRC_C_ZERO;
        endcase
      end
      MODE_UPDATE: begin
        strobes.bSel = SRC_B_IMM;
        strobes.wbEn = 1'b1;
        case (sizeCode)
          2'd0:    strobes.incStep = 3'd1;
          2'd1:    strobes.incStep = 3'd2;
          default: strobes.incStep = 3'd4;
        endcase
      end
      MODE_REG_IND:  strobes.bSel = SRC_B_ZERO;
      default:       strobes.zeroOut = 1'b1;
    endcase
  end

  // R10: at most one of the special output paths is active at a time
  always_comb begin
    p_paths_exclusive_r10: assert ($onehot0({strobes.jumpPath, strobes.zeroOut, strobes.wbEn}))
      else $error("more than one output path strobe active");
  end

endmodule

// File: rtl/eag_datapath.sv
module eag_datapath
  import eag_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int SHORT_IMM_W  = 16,
  parameter int NARROW_DSP_W = 8,
  parameter int JUMP_FIELD_W = 26
) (
  input  eagStrobes_t       strobes,
  input  logic [ADDR_W-1:0] pcVal,
  input  logic [ADDR_W-1:0] baseVal,
  input  logic [ADDR_W-1:0] indexVal,
  input  logic [ADDR_W-1:0] immField,
  output logic [ADDR_W-1:0] effAddr,
  output logic [ADDR_W-1:0] newBase
);

  localparam int PC_HI_W = ADDR_W - JUMP_FIELD_W - 2;

  logic [ADDR_W-1:0] opA, opB, opC, sumAddr, jumpAddr, stepExt, stepDiff;

  always_comb begin
    opA = (strobes.aSel == SRC_A_PC) ? pcVal : baseVal;
    case (strobes.bSel)
      SRC_B_IMM:   opB = {{(ADDR_W-SHORT_IMM_W){immField[SHORT_IMM_W-1]}},
                          immField[SHORT_IMM_W-1:0]};
      SRC_B_INDEX: opB = indexVal << strobes.shiftAmt;
      default:     opB = '0;
    endcase
    case (strobes.cSel)
      SRC_C_NARROW: opC = {{(ADDR_W-NARROW_DSP_W){immField[NARROW_DSP_W-1]}},
                           immField[NARROW_DSP_W-1:0]};
      SRC_C_WIDE:   opC = immField;
      default:      opC = '0;
    endcase
  end

  assign sumAddr  = opA + opB + opC;
  assign jumpAddr = {pcVal[ADDR_W-1 -: PC_HI_W], immField[JUMP_FIELD_W-1:0], 2'b00};
  assign stepExt  = {{(ADDR_W-3){1'b0}}, strobes.incStep};

  always_comb begin
    if (strobes.zeroOut)       effAddr = '0;
    else if (strobes.jumpPath) effAddr = jumpAddr;
    else                       effAddr = sumAddr;
  end

  assign newBase  = strobes.wbEn ? (baseVal + stepExt) : baseVal;
  assign stepDiff = newBase - baseVal;

  // R3: a jump target keeps the PC region and is word aligned
  always_comb begin
    if (strobes.jumpPath) begin
      p_jump_frame_r3: assert (effAddr[1:0] == 2'b00 &&
                               effAddr[ADDR_W-1 -: PC_HI_W] == pcVal[ADDR_W-1 -: PC_HI_W])
        else $error("jump target frame broken");
    end
  end

  // R7: the written-back base differs from the old one by 1, 2 or 4 (mod 2^32)
  always_comb begin
    if (strobes.wbEn) begin
      p_update_step_r7: assert (stepDiff == 1 || stepDiff == 2 || stepDiff == 4)
        else $error("update step not a legal operand size");
    end
  end

endmodule

// File: rtl/eff_addr_gen.sv
module eff_addr_gen
  import eag_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int SHORT_IMM_W  = 16,
  parameter int NARROW_DSP_W = 8,
  parameter int JUMP_FIELD_W = 26
) (
  input  logic [2:0]        modeSel,
  input  logic [1:0]        dispSel,
  input  logic [1:0]        scaleCode,
  input  logic [1:0]        sizeCode,
  input  logic [ADDR_W-1:0] pcVal,
  input  logic [ADDR_W-1:0] baseVal,
  input  logic [ADDR_W-1:0] indexVal,
  input  logic [ADDR_W-1:0] immField,
  output logic [ADDR_W-1:0] effAddr,
  output logic [ADDR_W-1:0] newBase,
  output logic              baseWrEn
);

  eagStrobes_t strobes;

  eag_ctrl u_ctrl (
    .modeSel  (modeSel),
    .dispSel  (dispSel),
    .scaleCode(scaleCode),
    .sizeCode (sizeCode),
    .strobes  (strobes)
  );

  eag_datapath #(
    .ADDR_W      (ADDR_W),
    .SHORT_IMM_W (SHORT_IMM_W),
    .NARROW_DSP_W(NARROW_DSP_W),
    .JUMP_FIELD_W(JUMP_FIELD_W)
  ) u_dp (
    .strobes (strobes),
    .pcVal   (pcVal),
    .baseVal (baseVal),
    .indexVal(indexVal),
    .immField(immField),
    .effAddr (effAddr),
    .newBase (newBase)
  );

  assign baseWrEn = strobes.wbEn;

  // R10: without write-back the base leaves the block unchanged
  always_comb begin
    if (!baseWrEn) begin
      p_base_held_r10: assert (newBase == baseVal)
        else $error("base changed without write-back");
    end
  end

  // R8: register-indirect mode passes the base straight through
  always_comb begin
    if (modeSel == 3'd6) begin
      p_reg_indirect_r8: assert (effAddr == baseVal)
        else $error("register-indirect address differs from base");
    end
  end

endmodule

// File: tb/sim_eff_addr_gen.sv
module sim_eff_addr_gen;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 16;
  localparam int VW = 202;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [2:0]  modeSel;
  logic [1:0]  dispSel, scaleCode, sizeCode;
  logic [31:0] pcVal, baseVal, indexVal, immField;
  logic [31:0] effAddr, newBase;
  logic        baseWrEn;

  eff_addr_gen u0 (
    .modeSel(modeSel), .dispSel(dispSel), .scaleCode(scaleCode), .sizeCode(sizeCode),
    .pcVal(pcVal), .baseVal(baseVal), .indexVal(indexVal), .immField(immField),
    .effAddr(effAddr), .newBase(newBase), .baseWrEn(baseWrEn)
  );

  // {mode, disp, scale, size, pc, base, index, imm, expAddr, expNewBase, expWb}
  localparam logic [VW-1:0] VECS [NVEC] = '{
    {3'd0,2'd0,2'd0,2'd0, 32'h0, 32'h0000_1000, 32'h0, 32'h0000_0010, 32'h0000_1010, 32'h0000_1000, 1'b0}, // R1
    {3'd0,2'd0,2'd0,2'd0, 32'h0, 32'h0000_1000, 32'h0, 32'hABCD_FFF0, 32'h0000_0FF0, 32'h0000_1000, 1'b0}, // R1 negative
    {3'd1,2'd0,2'd0,2'd0, 32'h0040_0000, 32'h0000_1234, 32'h0, 32'h0000_8000, 32'h003F_8000, 32'h0000_1234, 1'b0}, // R2
    {3'd2,2'd0,2'd0,2'd0, 32'hA123_4567, 32'h0, 32'h0, 32'hFC00_0001, 32'hA000_0004, 32'h0, 1'b0}, // R3
    {3'd3,2'd0,2'd0,2'd0, 32'h0, 32'h8000_0000, 32'h8000_0004, 32'h0, 32'h0000_0004, 32'h8000_0000, 1'b0}, // R4 R9
    {3'd4,2'd0,2'd3,2'd0, 32'h0, 32'h0000_0100, 32'h0000_0010, 32'h0, 32'h0000_0180, 32'h0000_0100, 1'b0}, // R5
    {3'd4,2'd1,2'd2,2'd0, 32'h0, 32'h0000_0100, 32'h0000_0003, 32'h0000_00FE, 32'h0000_010A, 32'h0000_0100, 1'b0}, // R6 narrow
    {3'd4,2'd2,2'd1,2'd0, 32'h0, 32'h0000_0100, 32'h0000_0005, 32'h1000_0000, 32'h1000_010A, 32'h0000_0100, 1'b0}, // R6 wide
    {3'd4,2'd3,2'd0,2'd0, 32'h0, 32'h0000_0100, 32'h0000_0001, 32'hFFFF_FFFF, 32'h0000_0101, 32'h0000_0100, 1'b0}, // R6 code 3
    {3'd5,2'd0,2'd0,2'd0, 32'h0, 32'h0000_2000, 32'h0, 32'h0000_0004, 32'h0000_2004, 32'h0000_2001, 1'b1}, // R7 byte
    {3'd5,2'd0,2'd0,2'd1, 32'h0, 32'h0000_2000, 32'h0, 32'h0000_FFFC, 32'h0000_1FFC, 32'h0000_2002, 1'b1}, // R7 half
    {3'd5,2'd0,2'd0,2'd3, 32'h0, 32'hFFFF_FFFE, 32'h0, 32'h0, 32'hFFFF_FFFE, 32'h0000_0002, 1'b1}, // R7 R9 wrap
    {3'd6,2'd0,2'd0,2'd0, 32'h0, 32'h3333_0000, 32'h0000_0009, 32'h0000_7FFF, 32'h3333_0000, 32'h3333_0000, 1'b0}, // R8
    {3'd7,2'd0,2'd0,2'd0, 32'h0, 32'h0000_0055, 32'h0, 32'h0, 32'h0, 32'h0000_0055, 1'b0}, // R10
    {3'd0,2'd2,2'd3,2'd2, 32'h0, 32'h0000_1000, 32'h0000_0007, 32'h0001_0010, 32'h0000_1010, 32'h0000_1000, 1'b0}, // R11
    {3'd4,2'd0,2'd3,2'd0, 32'h0, 32'h0, 32'h2000_0001, 32'h0, 32'h0000_0008, 32'h0, 1'b0}  // R5 shift-out
  };

  int checkCount = 0;
  int failCount  = 0;
  bit finished   = 1'b0;

  function automatic string tagOf(input logic [2:0] m);
    case (m)
      3'd0: return "R1/R11";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4/R9";
      3'd4: return "R5/R6";
      3'd5: return "R7/R9";
      3'd6: return "R8";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] m, input logic [1:0] d, input logic [1:0] s,
                       input logic [1:0] z, input logic [31:0] pc, input logic [31:0] b,
                       input logic [31:0] x, input logic [31:0] imm);
    @(posedge clk);
    modeSel = m; dispSel = d; scaleCode = s; sizeCode = z;
    pcVal = pc; baseVal = b; indexVal = x; immField = imm;
    @(negedge clk);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    checkCount++;
    failCount++;
    $display("FAIL watchdog: actual running expected done");
    finish();
  end

  initial begin
    // idle state: all inputs zero, mode 0 (R1, R10)
    drive(3'd0, 2'd0, 2'd0, 2'd0, 32'h0, 32'h0, 32'h0, 32'h0);
    check("R1", "idle effAddr", effAddr, 32'h0);
    check("R10", "idle baseWrEn", {31'b0, baseWrEn}, 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      logic [VW-1:0] v;
      v = VECS[i];
      drive(v[201:199], v[198:197], v[196:195], v[194:193],
            v[192:161], v[160:129], v[128:97], v[96:65]);
      check(tagOf(v[201:199]), $sformatf("vec %0d effAddr", i), effAddr, v[64:33]);
      check(tagOf(v[201:199]), $sformatf("vec %0d newBase", i), newBase, v[32:1]);
      check(tagOf(v[201:199]), $sformatf("vec %0d baseWrEn", i), {31'b0, baseWrEn}, {31'b0, v[0]});
    end

    // R3 corner: all-ones region and field
    drive(3'd2, 2'd0, 2'd0, 2'd0, 32'hF000_0000, 32'h0, 32'h0, 32'h03FF_FFFF);
    check("R3", "jump all ones", effAddr, 32'hFFFF_FFFC);
    // R7 word step with sizeCode 2
    drive(3'd5, 2'd0, 2'd0, 2'd2, 32'h0, 32'h0000_0010, 32'h0, 32'h0);
    check("R7", "word step", newBase, 32'h0000_0014);
    // R11: scale and disp codes ignored in indexed mode
    drive(3'd3, 2'd2, 2'd3, 2'd1, 32'h0, 32'h0000_0100, 32'h0000_0002, 32'h0000_1000);
    check("R11", "indexed ignores scale/disp", effAddr, 32'h0000_0102);
    // R10: PC-relative does not write back even with a size code
    drive(3'd1, 2'd0, 2'd0, 2'd2, 32'h0000_0100, 32'h0000_0040, 32'h0, 32'h0000_0004);
    check("R10", "no write-back in PC-relative", {31'b0, baseWrEn}, 32'h0);
    check("R2", "PC-relative small", effAddr, 32'h0000_0104);

    finish();
  end

endmodule